// File: doc/BRIEF.md
# Binary entry game controller

This block is the scoring core of a binary-entry quiz game. It presents an 8-bit challenge number. The player tries to set eight switches to the same bit pattern. The switch byte is synchronised and then compared with the challenge only on a slow periodic poll tick. When the whole byte matches, the score goes up by one and a new pseudo-random challenge replaces the old one on that same clock edge.

The pseudo-random sequence is an 8-bit Galois LFSR. Its output is mixed with a seed byte, which is taken from the upper bits of an externally converted analog sample. The block asks for such a sample on its own periodic request tick. That tick is independent of the poll tick. Each accepted sample replaces the seed.

Downstream logic converts the challenge to three decimal digits and the score to two. A one-cycle strobe tells it when the challenge has changed. Switch debouncing, the converter itself, display driving and round timing all live elsewhere.

Top module: `binquiz_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the score becomes 0, the challenge becomes RESET_STATE (default 0x5A) and `new_chal` is low. In the first cycle after reset is released, `new_chal` is high for exactly one cycle, announcing that first challenge.
- R2: Bit i of `switches` is switch i. It passes through SYNC_STAGES (default 2) flops before it is compared. The comparison happens only on the poll tick. The poll tick acts on every POLL_DIV-th rising edge after reset release, first on the POLL_DIV-th edge, and a match at any other edge has no effect on score or challenge.
- R3: On a poll tick whose synchronised switch byte equals the challenge, the score and the challenge both update on that same edge.
- R4: The next challenge is computed from the current challenge s in three steps. First, n = s >> 1. Second, if s[0] was 1, n is XORed with 0xB8. Third, n is XORed with the current seed byte.
- R5: If the R4 result is 0x00, the challenge becomes 0x01 instead, so the challenge is never zero.
- R6: The seed is 0 after reset. On an edge with `sample_valid` high, it becomes `sample_data[SAMPLE_W-1:SAMPLE_W-8]`. A hit on that same edge still uses the old seed.
- R7: `sample_req` is high for one cycle in every SAMPLE_DIV (default 37) cycles. The first such cycle is the SAMPLE_DIV-th cycle after reset release. This tick is independent of the poll tick.
- R8: The score saturates at SCORE_MAX (default 99). A hit at saturation still replaces the challenge.
- R9: `new_chal` is high in exactly the cycles that follow a challenge update, including the reset announcement of R1.
- R10: Holding a matching switch byte across many poll ticks adds one point only, because the challenge moves on at the first hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| switches | input | 8 | Player switch byte, bit i is switch i |
| sample_valid | input | 1 | A converted analog sample is present |
| sample_data | input | SAMPLE_W | Converted sample; its top 8 bits become the seed |
| sample_req | output | 1 | One-cycle request for a new analog sample |
| challenge | output | 8 | Current challenge value |
| score | output | SCORE_W | Current score, 0 to SCORE_MAX |
| new_chal | output | 1 | One-cycle strobe after every challenge update |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:

- **Held switches.** A matching byte is held over many poll ticks. A design that compared on every clock, or did not move the challenge on a hit, would score repeatedly.
- **Early match.** Right after a hit, the switches are set to the new challenge. The bench expects nothing to happen until the next poll edge, so an off-by-one poll divider or a missing synchroniser shows up as a score arriving early or late.
- **Seed timing and zero result.** A seed is loaded just before a hit and the expected challenge is computed from it. The seed is also chosen so that the mix comes out as zero, which must be replaced by 0x01. A wrong tap mask, a stale seed, or a dropped zero guard all give the wrong challenge.
- **Saturation.** The score is driven past 99. A counter that wrapped, or that froze the challenge at saturation, would be caught.

// File: rtl/binquiz_pkg.sv
// Package: shared types, default constants and the challenge update function
// for the binary entry game controller.
// Assumes the challenge and seed are always one byte wide, as the game defines.
package binquiz_pkg;

    typedef logic [7:0] byte_t;

    localparam byte_t DEF_TAPS        = 8'hB8;
    localparam byte_t DEF_RESET_STATE = 8'h5A;
    localparam int    DEF_SCORE_MAX   = 99;

    // One Galois step (right shift, XOR the tap mask when the dropped bit was 1),
    // then mix in the seed, then replace a zero result by 0x01.
    function automatic byte_t chal_advance(byte_t cur, byte_t taps, byte_t seed);
        byte_t nxt;
        nxt = cur >> 1;
        if (cur[0]) begin
            nxt = nxt ^ taps;
        end
        nxt = nxt ^ seed;
        if (nxt == 8'h00) begin
            nxt = 8'h01;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/bq_tick_div.sv
// Module: periodic tick divider.
// Produces a one-cycle tick in every DIV cycles; the first tick is in the
// DIV-th cycle after reset release. Assumes DIV >= 2.
module bq_tick_div #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    // Purpose: count 0..DIV-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/bq_sync.sv
// Module: multi-stage synchroniser for the switch byte.
// STAGES flops in series, cleared by reset; STAGES = 0 gives a plain wire.
// Assumes the switches are already debounced well enough at the poll rate.
module bq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    generate
        if (STAGES == 0) begin : g_wire
            assign dout = din;
        end else begin : g_chain
            logic [W-1:0] stage_q [STAGES];
            for (genvar i = 0; i < STAGES; i++) begin : g_stage
                if (i == 0) begin : g_first
                    // Purpose: capture the raw switch byte.
                    always_ff @(posedge clk) begin
                        if (!rst_n) stage_q[0] <= '0;
                        else        stage_q[0] <= din;
                    end
                end else begin : g_next
                    // Purpose: pass the byte one stage further.
                    always_ff @(posedge clk) begin
                        if (!rst_n) stage_q[i] <= '0;
                        else        stage_q[i] <= stage_q[i-1];
                    end
                end
            end
            assign dout = stage_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/bq_seed_reg.sv
// Module: seed register fed by the analog sample port.
// Keeps the top SEED_W bits of each valid sample; cleared to 0 by reset.
// Assumes SAMPLE_W >= SEED_W.
module bq_seed_reg #(
    parameter int SAMPLE_W = 10,
    parameter int SEED_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_data,
    output logic [SEED_W-1:0]   seed
);
    localparam int DROP = SAMPLE_W - SEED_W;

    // Purpose: replace the seed on every accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seed <= '0;
        end else if (sample_valid) begin
            seed <= sample_data[SAMPLE_W-1 -: SEED_W];
        end
    end

    generate
        if (DROP > 0) begin : g_drop
            logic unused_low;
            assign unused_low = ^sample_data[DROP-1:0];
        end
    endgenerate
endmodule

// File: rtl/bq_target_gen.sv
// Module: challenge generator.
// Holds the current challenge; on advance it steps the Galois LFSR, mixes in
// the seed and forces a nonzero result. Assumes RESET_STATE is nonzero.
module bq_target_gen
    import binquiz_pkg::*;
#(
    parameter byte_t TAPS        = DEF_TAPS,
    parameter byte_t RESET_STATE = DEF_RESET_STATE
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  advance,
    input  byte_t seed,
    output byte_t target
);
    // Purpose: hold the challenge, replacing it on each hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= RESET_STATE;
        end else if (advance) begin
            target <= chal_advance(target, TAPS, seed);
        end
    end
endmodule

// File: rtl/bq_score.sv
// Module: saturating score counter.
// Counts hits from 0 up to MAX and stays there. Assumes MAX fits in W bits.
module bq_score #(
    parameter int W   = 8,
    parameter int MAX = 99
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] score
);
    localparam logic [W-1:0] TOP = W'(MAX);

    // Purpose: add one point per hit until the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            score <= '0;
        end else if (inc && (score != TOP)) begin
            score <= score + 1'b1;
        end
    end
endmodule

// File: rtl/binquiz_core.sv
// Module: binary entry game controller (top).
// Polls the synchronised switch byte on a slow tick, scores an exact match,
// replaces the challenge with a reseeded pseudo-random value, and requests
// analog samples for the seed on an independent tick.
// Assumes POLL_DIV > SYNC_STAGES and both dividers are >= 2.
module binquiz_core
    import binquiz_pkg::*;
#(
    parameter int    POLL_DIV    = 50,
    parameter int    SAMPLE_DIV  = 37,
    parameter int    SYNC_STAGES = 2,
    parameter int    SAMPLE_W    = 10,
    parameter int    SCORE_W     = 8,
    parameter int    SCORE_MAX   = DEF_SCORE_MAX,
    parameter byte_t TAPS        = DEF_TAPS,
    parameter byte_t RESET_STATE = DEF_RESET_STATE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          switches,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_data,
    output logic                sample_req,
    output logic [7:0]          challenge,
    output logic [SCORE_W-1:0]  score,
    output logic                new_chal
);
    logic  poll_tick;
    byte_t sw_sync;
    byte_t seed;
    logic  hit;
    logic  boot_q;
    logic  strobe_q;

    bq_tick_div #(.DIV(POLL_DIV)) u_poll (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (poll_tick)
    );

    bq_tick_div #(.DIV(SAMPLE_DIV)) u_sreq (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (sample_req)
    );

    bq_sync #(.W(8), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (switches),
        .dout (sw_sync)
    );

    bq_seed_reg #(.SAMPLE_W(SAMPLE_W), .SEED_W(8)) u_seed (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_valid(sample_valid),
        .sample_data (sample_data),
        .seed        (seed)
    );

    // Purpose: an exact full-byte match counts only on the poll tick.
    assign hit = poll_tick && (sw_sync == challenge);

    bq_target_gen #(.TAPS(TAPS), .RESET_STATE(RESET_STATE)) u_target (
        .clk    (clk),
        .rst_n  (rst_n),
        .advance(hit),
        .seed   (seed),
        .target (challenge)
    );

    bq_score #(.W(SCORE_W), .MAX(SCORE_MAX)) u_score (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (hit),
        .score(score)
    );

    // Purpose: strobe once after reset and once after every challenge update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_q   <= 1'b1;
            strobe_q <= 1'b0;
        end else begin
            boot_q   <= 1'b0;
            strobe_q <= boot_q | hit;
        end
    end

    assign new_chal = strobe_q;
endmodule

// File: rtl/binquiz_core_chk.sv
// Module: assertion checker for binquiz_core, attached by bind below.
module binquiz_core_chk #(
    parameter int SCORE_W   = 8,
    parameter int SCORE_MAX = 99
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sample_req,
    input logic [7:0]         challenge,
    input logic [SCORE_W-1:0] score,
    input logic               new_chal
);
    a_r3_score_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (score != $past(score))) |-> (score == $past(score) + 1'b1));

    a_r3_score_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (score != $past(score))) |-> new_chal);

    a_r8_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        score <= SCORE_W'(SCORE_MAX));

    a_r5_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        challenge != 8'h00);

    a_r9_change_strobed: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (challenge != $past(challenge))) |-> new_chal);

    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        new_chal |=> !new_chal);

    a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req |=> !sample_req);
endmodule

bind binquiz_core binquiz_core_chk #(
    .SCORE_W  (SCORE_W),
    .SCORE_MAX(SCORE_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_req(sample_req),
    .challenge (challenge),
    .score     (score),
    .new_chal  (new_chal)
);

// File: tb/tb_binquiz_core.sv
// Bench: cycle-level reference model plus directed corner cases and
// seeded random stimulus for binquiz_core.
module tb_binquiz_core;
    localparam int P  = 50;
    localparam int SD = 37;
    localparam int SW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    switches = '0;
    logic          sample_valid = 1'b0;
    logic [SW-1:0] sample_data = '0;
    logic          sample_req;
    logic [7:0]    challenge;
    logic [7:0]    score;
    logic          new_chal;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // model state
    int       m_pcnt, m_scnt, m_score;
    bit [7:0] m_chal, m_seed, m_pipe0, m_pipe1;
    bit       m_boot, m_strobe;

    binquiz_core #(
        .POLL_DIV(P), .SAMPLE_DIV(SD), .SYNC_STAGES(2), .SAMPLE_W(SW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .switches(switches),
        .sample_valid(sample_valid), .sample_data(sample_data),
        .sample_req(sample_req), .challenge(challenge),
        .score(score), .new_chal(new_chal)
    );

    always #5 clk = ~clk;

    function automatic bit [7:0] next_chal(bit [7:0] s, bit [7:0] sd);
        bit [7:0] n;
        n = {1'b0, s[7:1]};
        if (s[0]) n = n ^ 8'hB8;
        n = n ^ sd;
        if (n == 0) n = 8'h01;
        return n;
    endfunction

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    // one clock: drive at negedge, advance model, compare at next negedge
    task automatic cycle(bit [7:0] sw, bit sv, bit [SW-1:0] sd);
        bit       poll, hit;
        bit [7:0] nchal;
        switches = sw; sample_valid = sv; sample_data = sd;
        poll  = (m_pcnt == P - 1);
        hit   = poll && (m_pipe1 == m_chal);
        nchal = hit ? next_chal(m_chal, m_seed) : m_chal;
        if (hit && m_score < 99) m_score++;
        m_chal   = nchal;
        m_strobe = m_boot | hit;
        m_boot   = 0;
        if (sv) m_seed = sd[SW-1 -: 8];
        m_pipe1 = m_pipe0;
        m_pipe0 = sw;
        m_pcnt  = (m_pcnt == P - 1) ? 0 : m_pcnt + 1;
        m_scnt  = (m_scnt == SD - 1) ? 0 : m_scnt + 1;
        @(posedge clk);
        @(negedge clk);
        check("R4 challenge", challenge, m_chal);
        check("R3 score", score, m_score);
        check("R9 new_chal", new_chal, m_strobe);
        check("R7 sample_req", sample_req, (m_scnt == SD - 1));
    endtask

    task automatic run_to_phase(int ph);
        while (m_pcnt != ph) cycle(~m_chal, 0, '0);
    endtask

    initial begin
        int s0;
        bit [7:0] c0, exp_c;
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R1 reset score", score, 0);
        check("R1 reset challenge", challenge, 8'h5A);
        check("R1 reset strobe", new_chal, 0);
        rst_n = 1'b1;
        m_pcnt = 0; m_scnt = 0; m_score = 0; m_chal = 8'h5A; m_seed = 0;
        m_pipe0 = 0; m_pipe1 = 0; m_boot = 1; m_strobe = 0;
        cycle(8'h00, 0, '0);
        check("R1 boot strobe", new_chal, 1);
        cycle(8'h00, 0, '0);
        check("R1 boot strobe single", new_chal, 0);

        // R10: hold the matching byte across many polls (seed is 0)
        c0 = m_chal;
        s0 = m_score;
        repeat (5 * P) cycle(c0, 0, '0);
        check("R10 single score", score, s0 + 1);
        check("R10 challenge moved", challenge, next_chal(c0, 8'h00));

        // R2: match set right after a hit must wait for the next poll edge
        run_to_phase(P - 4);
        cycle(m_chal, 0, '0);
        while (!m_strobe) cycle(m_chal, 0, '0);
        s0 = m_score;
        c0 = m_chal;
        repeat (P - 1) begin
            cycle(c0, 0, '0);
            check("R2 no early score", score, s0);
        end
        cycle(c0, 0, '0);
        check("R2 score at poll edge", score, s0 + 1);

        // R6: seed loaded before a hit steers the next challenge
        run_to_phase(P - 3);
        c0 = m_chal;
        exp_c = next_chal(c0, 8'h3C);
        cycle(c0, 1, {8'h3C, 2'b11});
        cycle(c0, 0, '0);
        cycle(c0, 0, '0);
        check("R6 seeded challenge", challenge, exp_c);

        // R5: seed chosen so the mix is zero
        run_to_phase(P - 3);
        c0 = m_chal;
        exp_c = next_chal(c0, 8'h00);
        cycle(c0, 1, {exp_c, 2'b00});
        cycle(c0, 0, '0);
        cycle(c0, 0, '0);
        check("R5 zero forced to one", challenge, 8'h01);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit [7:0] sw;
            bit sv;
            sw = ($urandom % 3 == 0) ? m_chal : 8'($urandom);
            sv = ($urandom % 20 == 0);
            cycle(sw, sv, SW'($urandom));
        end

        // R8: drive to saturation and beyond
        while (m_score < 99) cycle(m_chal, 0, '0);
        for (int k = 0; k < 3; k++) begin
            c0 = m_chal;
            while (m_chal == c0) cycle(m_chal, 0, '0);
            check("R8 saturated score", score, 99);
            check("R8 challenge still advances", (challenge != c0), 1);
        end
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule